// File: doc/BRIEF.md
# Word Arithmetic and Increment Unit

This unit serves the execution stage of an 8-bit accumulator machine. In one operation it adds, subtracts or compares a 16-bit register-pair value against a 16-bit immediate word. It also increments or decrements a byte operand, or increments or decrements a register pair. The unit does not fetch or decode instructions. The surrounding datapath supplies an operation code, the operands and the current flag values, and it writes back the result when the unit asks for it.

The result, the write request and the zero (Z), auxiliary-carry (AC) and carry (CY) flags are captured on the clock edge where `start_i` is high. The unit raises `done_o` in the cycle after that edge. One shared 16-bit adder/subtractor handles every operation. Each operation class has its own rule for which flags it updates: compare updates flags only, the byte steps keep the carry, and the word steps keep all three flags.

Top module: `warith_unit`

## Requirements
- R1: Operation code `op_i` = 0 (word add) produces `result_o` = pair + imm mod 2^16 with `wr_en_o` = 1, and CY = carry out of bit 15.
- R2: Operation code 1 (word subtract) produces `result_o` = pair − imm mod 2^16 with `wr_en_o` = 1, and CY = 1 exactly when imm > pair (borrow).
- R3: Operation code 2 (word compare) updates Z, AC and CY as word subtract does, with `wr_en_o` = 0. `result_o` shows the difference.
- R4: For codes 0, 1 and 2, Z = 1 exactly when all 16 result bits are zero.
- R5: For codes 0, 1 and 2, AC is the carry (add) or borrow (subtract, compare) out of bit 7.
- R6: Codes 3 (byte increment) and 4 (byte decrement) produce `result_o[7:0]` = byte ± 1 mod 256 and `result_o[15:8]` = 0, with `wr_en_o` = 1. Z is set when the 8-bit result is zero, AC is the carry or borrow out of bit 3, and CY equals `cy_i`.
- R7: Codes 5 (pair increment) and 6 (pair decrement) produce pair ± 1 mod 2^16 with `wr_en_o` = 1, and Z, AC and CY equal `z_i`, `ac_i` and `cy_i`.
- R8: The result and flags are captured on a rising clock edge with `start_i` = 1. `done_o` is 1 for exactly the following cycle, and `wr_en_o` is 1 only in a cycle where `done_o` is 1. Without `start_i`, `result_o` and the flags hold their values.
- R9: While `rst_n` is low, `result_o`, `wr_en_o`, the flags and `done_o` are all 0.
- R10: Code 7 (no operation) gives `wr_en_o` = 0 and `result_o` = 0, and it copies `z_i`, `ac_i` and `cy_i` to the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture strobe for the current operation |
| op_i | input | 3 | Operation code (0..7) |
| pair_i | input | 16 | Register-pair operand |
| imm_i | input | 16 | Immediate word operand |
| byte_i | input | 8 | Byte operand for increment/decrement |
| z_i | input | 1 | Current zero flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| cy_i | input | 1 | Current carry flag |
| result_o | output | 16 | Registered result |
| wr_en_o | output | 1 | Result write request, one cycle |
| z_o | output | 1 | Updated zero flag |
| ac_o | output | 1 | Updated auxiliary-carry flag |
| cy_o | output | 1 | Updated carry flag |
| done_o | output | 1 | Operation complete, one cycle after `start_i` |

## Verification
The bench builds the unit with a 16-bit word, an 8-bit byte and the explicit ripple-carry adder variant. These values put the internal taps at bit 3 and bit 7 and the carry-out at bit 15. Short directed vectors such as 0x0F+1, 0x80+0x80 and 0xFFFF+1 can therefore hit every flag boundary and both wrap points. Operations are issued back to back and also with idle gaps. This shows that flags and results hold between strobes, and that the kept flags of the byte and word steps really follow the flag inputs.

// File: rtl/warith_pkg.sv
package warith_pkg;

   typedef enum logic [2:0] {
      OP_ADDW = 3'd0,
      OP_SUBW = 3'd1,
      OP_CMPW = 3'd2,
      OP_INCB = 3'd3,
      OP_DECB = 3'd4,
      OP_INCW = 3'd5,
      OP_DECW = 3'd6,
      OP_NONE = 3'd7
   } wop_e;

   typedef struct packed {
      logic z;
      logic ac;
      logic cy;
   } wflags_t;

endpackage

// File: rtl/warith_addsub.sv
module warith_addsub #(
   parameter int W      = 16,
   parameter int TAP_LO = 3,
   parameter int TAP_HI = 7,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         tap_lo_o,
   output logic         tap_hi_o,
   output logic         cout_o
);

   localparam int LO_W = TAP_LO + 2;
   localparam int HI_W = TAP_HI + 2;

   logic [W-1:0] bx;
   assign bx = sub_i ? ~b_i : b_i;

   generate
      if (TAP_LO >= TAP_HI || TAP_HI >= W - 1) begin : g_bad_taps
         $error("warith_addsub: taps must satisfy TAP_LO < TAP_HI < W-1");
      end

      if (RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = sub_i;
         for (genvar k = 0; k < W; k++) begin : g_bit
            assign sum_o[k] = a_i[k] ^ bx[k] ^ c[k];
            assign c[k+1]   = (a_i[k] & bx[k]) | (c[k] & (a_i[k] ^ bx[k]));
         end
         assign tap_lo_o = c[TAP_LO+1];
         assign tap_hi_o = c[TAP_HI+1];
         assign cout_o   = c[W];
      end else begin : g_behav
         logic [W:0]    full;
         logic [LO_W-1:0] part_lo;
         logic [HI_W-1:0] part_hi;
         assign full    = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};
         assign part_lo = {1'b0, a_i[TAP_LO:0]} + {1'b0, bx[TAP_LO:0]}
                          + {{(LO_W-1){1'b0}}, sub_i};
         assign part_hi = {1'b0, a_i[TAP_HI:0]} + {1'b0, bx[TAP_HI:0]}
                          + {{(HI_W-1){1'b0}}, sub_i};
         assign sum_o    = full[W-1:0];
         assign cout_o   = full[W];
         assign tap_lo_o = part_lo[LO_W-1];
         assign tap_hi_o = part_hi[HI_W-1];
      end
   endgenerate

endmodule

// File: rtl/warith_flags.sv
module warith_flags
   import warith_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  wop_e              op_i,
   input  logic [WORD_W-1:0] sum_i,
   input  logic              tap_lo_i,
   input  logic              tap_hi_i,
   input  logic              cout_i,
   input  wflags_t           flags_i,
   output logic [WORD_W-1:0] res_o,
   output logic              wr_o,
   output wflags_t           flags_o
);

   localparam int UP_W = WORD_W - BYTE_W;

   logic word_zero;
   logic byte_zero;
   assign word_zero = (sum_i == '0);
   assign byte_zero = (sum_i[BYTE_W-1:0] == '0);

   always_comb begin
      res_o   = sum_i;
      wr_o    = 1'b1;
      flags_o = flags_i;
      unique case (op_i)
         OP_ADDW: begin
            flags_o = '{z: word_zero, ac: tap_hi_i, cy: cout_i};
         end
         OP_SUBW: begin
            flags_o = '{z: word_zero, ac: ~tap_hi_i, cy: ~cout_i};
         end
         OP_CMPW: begin
            wr_o    = 1'b0;
            flags_o = '{z: word_zero, ac: ~tap_hi_i, cy: ~cout_i};
         end
         OP_INCB: begin
            res_o   = {{UP_W{1'b0}}, sum_i[BYTE_W-1:0]};
            flags_o = '{z: byte_zero, ac: tap_lo_i, cy: flags_i.cy};
         end
         OP_DECB: begin
            res_o   = {{UP_W{1'b0}}, sum_i[BYTE_W-1:0]};
            flags_o = '{z: byte_zero, ac: ~tap_lo_i, cy: flags_i.cy};
         end
         OP_INCW, OP_DECW: begin
            flags_o = flags_i;
         end
         default: begin
            res_o = '0;
            wr_o  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/warith_unit.sv
module warith_unit
   import warith_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [WORD_W-1:0] pair_i,
   input  logic [WORD_W-1:0] imm_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              z_i,
   input  logic              ac_i,
   input  logic              cy_i,
   output logic [WORD_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              z_o,
   output logic              ac_o,
   output logic              cy_o,
   output logic              done_o
);

   localparam int UP_W   = WORD_W - BYTE_W;
   localparam int TAP_LO = BYTE_W / 2 - 1;
   localparam int TAP_HI = BYTE_W - 1;

   generate
      if (WORD_W != 2 * BYTE_W || BYTE_W < 4) begin : g_bad_width
         $error("warith_unit: WORD_W must be twice BYTE_W and BYTE_W >= 4");
      end
   endgenerate

   wop_e              op;
   logic [WORD_W-1:0] opa, opb;
   logic              do_sub;
   logic [WORD_W-1:0] sum;
   logic              tap_lo, tap_hi, cout;
   logic [WORD_W-1:0] res_n;
   logic              wr_n;
   wflags_t           flags_in, flags_n, flags_q;

   assign op       = wop_e'(op_i);
   assign flags_in = '{z: z_i, ac: ac_i, cy: cy_i};

   always_comb begin
      opa    = pair_i;
      opb    = imm_i;
      do_sub = 1'b0;
      unique case (op)
         OP_ADDW: ;
         OP_SUBW, OP_CMPW: do_sub = 1'b1;
         OP_INCB: begin
            opa = {{UP_W{1'b0}}, byte_i};
            opb = WORD_W'(1);
         end
         OP_DECB: begin
            opa    = {{UP_W{1'b0}}, byte_i};
            opb    = WORD_W'(1);
            do_sub = 1'b1;
         end
         OP_INCW: opb = WORD_W'(1);
         OP_DECW: begin
            opb    = WORD_W'(1);
            do_sub = 1'b1;
         end
         default: ;
      endcase
   end

   warith_addsub #(
      .W      (WORD_W),
      .TAP_LO (TAP_LO),
      .TAP_HI (TAP_HI),
      .RIPPLE (RIPPLE)
   ) adder_i (
      .a_i      (opa),
      .b_i      (opb),
      .sub_i    (do_sub),
      .sum_o    (sum),
      .tap_lo_o (tap_lo),
      .tap_hi_o (tap_hi),
      .cout_o   (cout)
   );

   warith_flags #(
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W)
   ) flags_i (
      .op_i     (op),
      .sum_i    (sum),
      .tap_lo_i (tap_lo),
      .tap_hi_i (tap_hi),
      .cout_i   (cout),
      .flags_i  (flags_in),
      .res_o    (res_n),
      .wr_o     (wr_n),
      .flags_o  (flags_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         flags_q  <= '0;
         wr_en_o  <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o  <= start_i;
         wr_en_o <= start_i & wr_n;
         if (start_i) begin
            result_o <= res_n;
            flags_q  <= flags_n;
         end
      end
   end

   assign z_o  = flags_q.z;
   assign ac_o = flags_q.ac;
   assign cy_o = flags_q.cy;

endmodule

// File: rtl/warith_unit_chk.sv
module warith_unit_chk #(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        op_i,
   input logic              z_i,
   input logic              ac_i,
   input logic              cy_i,
   input logic [WORD_W-1:0] result_o,
   input logic              wr_en_o,
   input logic              z_o,
   input logic              ac_o,
   input logic              cy_o,
   input logic              done_o
);

   assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (!done_o && !wr_en_o && $stable(result_o) && $stable({z_o, ac_o, cy_o})));

   assert_write_only_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> done_o);

   assert_compare_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 3'd2) |=> !wr_en_o);

   assert_word_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i <= 3'd2) |=> (z_o == (result_o == '0)));

   assert_byte_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (op_i == 3'd3 || op_i == 3'd4)) |=>
         (cy_o == $past(cy_i) && result_o[WORD_W-1:BYTE_W] == '0));

   assert_pair_step_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (op_i == 3'd5 || op_i == 3'd6)) |=>
         ({z_o, ac_o, cy_o} == $past({z_i, ac_i, cy_i}) && wr_en_o));

   assert_none_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && op_i == 3'd7) |=>
         (!wr_en_o && result_o == '0 && {z_o, ac_o, cy_o} == $past({z_i, ac_i, cy_i})));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R9: assert (!done_o && !wr_en_o && result_o == '0);
      end
   end

endmodule

bind warith_unit warith_unit_chk #(
   .WORD_W (WORD_W),
   .BYTE_W (BYTE_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .op_i     (op_i),
   .z_i      (z_i),
   .ac_i     (ac_i),
   .cy_i     (cy_i),
   .result_o (result_o),
   .wr_en_o  (wr_en_o),
   .z_o      (z_o),
   .ac_o     (ac_o),
   .cy_o     (cy_o),
   .done_o   (done_o)
);

// File: tb/warith_unit_tb_top.sv
`timescale 1ns/1ps
module warith_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [15:0] pair_i = 16'h0;
   logic [15:0] imm_i = 16'h0;
   logic [7:0]  byte_i = 8'h0;
   logic        z_i = 1'b0, ac_i = 1'b0, cy_i = 1'b0;
   logic [15:0] result_o;
   logic        wr_en_o, z_o, ac_o, cy_o, done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [19:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   warith_unit #(.WORD_W(16), .BYTE_W(8), .RIPPLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .pair_i(pair_i), .imm_i(imm_i), .byte_i(byte_i),
      .z_i(z_i), .ac_i(ac_i), .cy_i(cy_i),
      .result_o(result_o), .wr_en_o(wr_en_o), .z_o(z_o), .ac_o(ac_o),
      .cy_o(cy_o), .done_o(done_o));

   task automatic check(input bit ok, input string req, input logic [19:0] act,
                        input logic [19:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (res,wr,z,ac,cy)", req, act, exp);
      end
   endtask

   // expected outcome computed from the requirements
   task automatic issue(input logic [2:0] op, input logic [15:0] p, input logic [15:0] i,
                        input logic [7:0] b, input logic fz, input logic fa, input logic fc,
                        input string req);
      logic [16:0] s;
      logic [15:0] r;
      logic        w, z, a, c;
      z = fz; a = fa; c = fc; w = 1'b1;
      case (op)
         3'd0: begin
            s = {1'b0, p} + {1'b0, i}; r = s[15:0]; c = s[16];
            a = ({1'b0, p[7:0]} + {1'b0, i[7:0]}) > 9'h0FF; z = (r == 0);
         end
         3'd1, 3'd2: begin
            r = p - i; c = (i > p); a = (i[7:0] > p[7:0]); z = (r == 0);
            w = (op == 3'd1);
         end
         3'd3: begin r = {8'h00, b + 8'd1}; z = (r == 0); a = (b[3:0] == 4'hF); end
         3'd4: begin r = {8'h00, b - 8'd1}; z = (r == 0); a = (b[3:0] == 4'h0); end
         3'd5: r = p + 16'd1;
         3'd6: r = p - 16'd1;
         default: begin r = 16'h0; w = 1'b0; end
      endcase
      @(negedge clk);
      op_i = op; pair_i = p; imm_i = i; byte_i = b;
      z_i = fz; ac_i = fa; cy_i = fc; start_i = 1'b1;
      exp_q.push_back({r, w, z, a, c});
      tag_q.push_back(req);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      start_i = 1'b0;
      op_i = 3'd0; z_i = 1'b1; ac_i = 1'b1; cy_i = 1'b1;
      repeat (n - 1) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected done", {result_o, wr_en_o, z_o, ac_o, cy_o}, 20'h0);
         end else begin
            logic [19:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({result_o, wr_en_o, z_o, ac_o, cy_o} == e, t,
                  {result_o, wr_en_o, z_o, ac_o, cy_o}, e);
         end
      end else if (rst_n && wr_en_o) begin
         check(1'b0, "R8 write without done", {result_o, wr_en_o, z_o, ac_o, cy_o}, 20'h0);
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check({result_o, wr_en_o, z_o, ac_o, cy_o, done_o} == 21'h0, "R9 reset",
            {result_o, wr_en_o, z_o, ac_o, cy_o}, 20'h0);
      rst_n = 1'b1;
      idle(2);

      // R1 / R4 / R5 word add
      issue(3'd0, 16'h1234, 16'h4321, 8'h00, 0, 0, 0, "R1 add plain");
      issue(3'd0, 16'hFFFF, 16'h0001, 8'h00, 0, 0, 0, "R1 R4 R5 add wrap to zero");
      issue(3'd0, 16'h0080, 16'h0080, 8'h00, 1, 0, 1, "R5 add carry from bit 7");
      issue(3'd0, 16'h8000, 16'h8000, 8'h00, 0, 1, 0, "R1 R4 add carry out only");
      // R2 word subtract
      issue(3'd1, 16'h5000, 16'h0001, 8'h00, 0, 0, 1, "R2 R5 sub borrow at bit 7");
      issue(3'd1, 16'h0001, 16'h0002, 8'h00, 0, 0, 0, "R2 sub borrow out");
      issue(3'd1, 16'hABCD, 16'hABCD, 8'h00, 0, 1, 1, "R2 R4 sub equal");
      idle(3);
      // R3 compare
      issue(3'd2, 16'h7777, 16'h7777, 8'h00, 0, 1, 1, "R3 R4 compare equal");
      issue(3'd2, 16'h0100, 16'h0200, 8'h00, 1, 1, 0, "R3 compare less");
      issue(3'd2, 16'h0300, 16'h00FF, 8'h00, 1, 0, 1, "R3 R5 compare greater");
      // R6 byte steps
      issue(3'd3, 16'hFFFF, 16'h0000, 8'hFF, 0, 0, 1, "R6 byte inc wrap");
      issue(3'd3, 16'h0000, 16'h0000, 8'h0F, 1, 0, 0, "R6 byte inc nibble carry");
      issue(3'd4, 16'h0000, 16'h0000, 8'h00, 0, 0, 1, "R6 byte dec wrap");
      issue(3'd4, 16'h0000, 16'h0000, 8'h01, 0, 1, 0, "R6 byte dec to zero");
      issue(3'd4, 16'h0000, 16'h0000, 8'h10, 0, 0, 0, "R6 byte dec nibble borrow");
      idle(2);
      // R7 pair steps
      issue(3'd5, 16'hFFFF, 16'h0000, 8'h00, 0, 1, 0, "R7 pair inc wrap");
      issue(3'd6, 16'h0000, 16'h0000, 8'h00, 1, 0, 1, "R7 pair dec wrap");
      issue(3'd5, 16'h00FF, 16'h0000, 8'h00, 0, 0, 0, "R7 pair inc mid");
      // R10 no operation
      issue(3'd7, 16'h1234, 16'h5678, 8'h9A, 1, 0, 1, "R10 no operation");
      idle(3);
      // R8: outputs hold after idle with changed flag inputs
      check({result_o, z_o, ac_o, cy_o} == {16'h0000, 1'b1, 1'b0, 1'b1} && !done_o,
            "R8 hold while idle", {result_o, wr_en_o, z_o, ac_o, cy_o},
            {16'h0000, 1'b0, 1'b1, 1'b0, 1'b1});
      check(exp_q.size() == 0, "R8 all results returned",
            20'(exp_q.size()), 20'h0);
      finish_run();
   end

endmodule